// File: doc/BRIEF.md
# I2C EEPROM Transaction Sequencer

This block runs whole register or EEPROM transfers over a two-wire serial bus by driving a separate bit-level engine. A request gives the operation (read, write or probe), a 7-bit device address, an internal address of 0 to `ADDR_BYTES` bytes, and a byte count. The sequencer then issues primitive bus commands one at a time. It waits for the engine's response to each command before it issues the next.

Write data comes in through a valid/ready byte port and read data goes out through another. At the end of each transfer a status word is left on the outputs. This word holds a done flag, a missing-device flag, an address-rejected flag and a count of write bytes the device refused. When `OVF_MASK` is nonzero, the bits of the internal address above the configured address length are masked and merged into the device address, so one large memory can appear as several small devices. The first request after reset is preceded by a bus-recovery command.

Top module: `i2c_seq_top`

## Requirements
- R1: The first request accepted after reset issues a RESET command (code 0) before its START. Later requests do not issue RESET.
- R2: Internal address bytes are written most significant byte first, and exactly `req_alen_i` of them are written.
- R3: The device byte that is sent is {dev, rw}, where dev = chip OR ((addr >> 8*alen) AND `OVF_MASK`).
- R4: A read with a nonzero address length sends START, the device byte with rw=0, the address bytes, STOP, START and the device byte with rw=1, in that order.
- R5: A read with a zero address length sends START and then the device byte with rw=1, with no write phase.
- R6: A read of N bytes issues N-1 read-with-ACK commands (code 4), then one read-with-NACK command (code 5), then STOP. Each byte is presented on the read port and held until `rdata_ready_i` accepts it.
- R7: A NACK on the rw=0 device byte ends the transfer with STOP alone and sets the missing-device flag.
- R8: A NACK on an address byte ends the transfer with STOP alone and sets the address-rejected flag. The missing-device flag stays clear.
- R9: A write sends START, the rw=0 device byte, the address bytes and then every data byte. A NACK on a data byte does not stop the transfer but adds one to the failure count.
- R10: A probe sends START, the rw=0 device byte and STOP. The missing-device flag reports whether that byte was refused.
- R11: At reset the status is all zero and `req_ready_o` is high. Accepting a request clears the status. After the closing STOP the done flag rises, and the status then holds until the next request is accepted.
- R12: Command codes are 0 RESET, 1 START, 2 STOP, 3 WRITE, 4 read-with-ACK and 5 read-with-NACK. A command and its data stay stable while `eng_cmd_valid_o` is high and `eng_cmd_ready_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Idle and able to take a request |
| req_op_i | input | 2 | 0 read, 2 probe, 1 or 3 write |
| req_chip_i | input | 7 | Device address |
| req_addr_i | input | 8*ADDR_BYTES | Internal address |
| req_alen_i | input | ALEN_W | Address length in bytes, 0 to ADDR_BYTES |
| req_len_i | input | LEN_W | Data byte count |
| wdata_valid_i | input | 1 | Write byte valid |
| wdata_ready_o | output | 1 | Write byte taken |
| wdata_i | input | 8 | Write byte |
| rdata_valid_o | output | 1 | Read byte valid |
| rdata_ready_i | input | 1 | Read byte taken |
| rdata_o | output | 8 | Read byte |
| eng_cmd_valid_o | output | 1 | Command to engine valid |
| eng_cmd_ready_i | input | 1 | Engine takes command |
| eng_cmd_o | output | 3 | Command code |
| eng_cmd_data_o | output | 8 | Byte for a WRITE command, zero otherwise |
| eng_rsp_valid_i | input | 1 | Engine finished the command |
| eng_rsp_nack_i | input | 1 | Byte was refused (WRITE commands) |
| eng_rsp_data_i | input | 8 | Byte received (read commands) |
| st_done_o | output | 1 | Transfer finished |
| st_nodev_o | output | 1 | Device byte refused |
| st_addr_nack_o | output | 1 | Address byte refused |
| st_fail_cnt_o | output | 8 | Refused write data bytes, saturating |

## Verification
The hardest state to reach is a refusal on one particular address byte or data byte in the middle of a long transfer, with the command stream stalled at the same time. The bench's engine model answers from a per-command table built beforehand from the requirements, so any chosen position can be made to NACK. The ready inputs on the engine, write and read ports follow different periodic stall patterns, so commands and bytes are held across stalls throughout the sweep.

// File: rtl/i2c_seq_pkg.sv
`timescale 1ns/1ps
package i2c_seq_pkg;
  typedef enum logic [2:0] {
    CMD_RESET = 3'd0, CMD_START = 3'd1, CMD_STOP = 3'd2,
    CMD_WRITE = 3'd3, CMD_RD_ACK = 3'd4, CMD_RD_NACK = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1, OP_PROBE = 2'd2} op_e;

  typedef enum logic [3:0] {
    PH_IDLE, PH_RESET, PH_START1, PH_CHIPW, PH_ADDR, PH_MSTOP,
    PH_START2, PH_CHIPR, PH_RD, PH_RDOUT, PH_WGET, PH_WR, PH_STOP
  } ph_e;

  typedef struct packed {
    logic       done;
    logic       nodev;
    logic       addr_nack;
    logic [7:0] fails;
  } status_t;
endpackage

// File: rtl/i2c_seq_addr.sv
`timescale 1ns/1ps
module i2c_seq_addr #(
  parameter int         ADDR_BYTES = 4,
  parameter logic [6:0] OVF_MASK   = 7'h00,
  localparam int        ALEN_W     = $clog2(ADDR_BYTES + 1),
  localparam int        AW         = ADDR_BYTES * 8
) (
  input  logic [6:0]        chip_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [ALEN_W-1:0] alen_i,
  input  logic [ALEN_W-1:0] idx_i,
  output logic [6:0]        chip_eff_o,
  output logic [7:0]        addr_byte_o
);
  assign addr_byte_o = addr_i[{idx_i, 3'b000} +: 8];

  generate
    if (OVF_MASK != 7'h00) begin : g_ovf
      logic [AW+6:0] ext;
      assign ext        = {7'h00, addr_i};
      assign chip_eff_o = chip_i | (ext[{alen_i, 3'b000} +: 7] & OVF_MASK);
    end else begin : g_plain
      assign chip_eff_o = chip_i;
    end
  endgenerate
endmodule

// File: rtl/i2c_seq_status.sv
`timescale 1ns/1ps
module i2c_seq_status
  import i2c_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    clr_i,
  input  logic    done_i,
  input  logic    nodev_i,
  input  logic    anack_i,
  input  logic    fail_i,
  output status_t st_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o <= '0;
    end else if (clr_i) begin
      st_o <= '0;
    end else begin
      if (done_i)  st_o.done      <= 1'b1;
      if (nodev_i) st_o.nodev     <= 1'b1;
      if (anack_i) st_o.addr_nack <= 1'b1;
      if (fail_i && st_o.fails != 8'hFF) st_o.fails <= st_o.fails + 8'd1;
    end
  end
endmodule

// File: rtl/i2c_seq_ctrl.sv
`timescale 1ns/1ps
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
#(
  parameter int  ADDR_BYTES = 4,
  parameter int  LEN_W      = 8,
  localparam int ALEN_W     = $clog2(ADDR_BYTES + 1),
  localparam int AW         = ADDR_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [6:0]        req_chip_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [ALEN_W-1:0] req_alen_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              wdata_valid_i,
  output logic              wdata_ready_o,
  input  logic [7:0]        wdata_i,
  output logic              rdata_valid_o,
  input  logic              rdata_ready_i,
  output logic [7:0]        rdata_o,
  output logic              eng_cmd_valid_o,
  input  logic              eng_cmd_ready_i,
  output logic [2:0]        eng_cmd_o,
  output logic [7:0]        eng_cmd_data_o,
  input  logic              eng_rsp_valid_i,
  input  logic              eng_rsp_nack_i,
  input  logic [7:0]        eng_rsp_data_i,
  output logic [6:0]        chip_o,
  output logic [AW-1:0]     addr_o,
  output logic [ALEN_W-1:0] alen_o,
  output logic [ALEN_W-1:0] idx_o,
  input  logic [6:0]        chip_eff_i,
  input  logic [7:0]        addr_byte_i,
  output logic              ev_clr_o,
  output logic              ev_done_o,
  output logic              ev_nodev_o,
  output logic              ev_anack_o,
  output logic              ev_fail_o
);
  ph_e              ph_q;
  op_e              op_q;
  logic             wait_q, init_q;
  logic [LEN_W-1:0] cnt_q;
  logic [7:0]       byte_q;
  logic             rsp_ok, has_cmd, last_q;
  cmd_e             cmd;

  assign rsp_ok  = wait_q && eng_rsp_valid_i;
  assign last_q  = (cnt_q == LEN_W'(1));
  assign has_cmd = !(ph_q inside {PH_IDLE, PH_RDOUT, PH_WGET});

  assign req_ready_o     = (ph_q == PH_IDLE);
  assign wdata_ready_o   = (ph_q == PH_WGET);
  assign rdata_valid_o   = (ph_q == PH_RDOUT);
  assign rdata_o         = byte_q;
  assign eng_cmd_valid_o = has_cmd && !wait_q;
  assign eng_cmd_o       = cmd;

  always_comb begin
    cmd            = CMD_STOP;
    eng_cmd_data_o = 8'h00;
    case (ph_q)
      PH_RESET:             cmd = CMD_RESET;
      PH_START1, PH_START2: cmd = CMD_START;
      PH_CHIPW: begin cmd = CMD_WRITE; eng_cmd_data_o = {chip_eff_i, 1'b0}; end
      PH_ADDR:  begin cmd = CMD_WRITE; eng_cmd_data_o = addr_byte_i; end
      PH_CHIPR: begin cmd = CMD_WRITE; eng_cmd_data_o = {chip_eff_i, 1'b1}; end
      PH_WR:    begin cmd = CMD_WRITE; eng_cmd_data_o = byte_q; end
      PH_RD:                cmd = last_q ? CMD_RD_NACK : CMD_RD_ACK;
      default:              cmd = CMD_STOP;
    endcase
  end

  assign ev_clr_o   = (ph_q == PH_IDLE) && req_valid_i;
  assign ev_done_o  = rsp_ok && (ph_q == PH_STOP);
  assign ev_nodev_o = rsp_ok && (ph_q == PH_CHIPW) && eng_rsp_nack_i;
  assign ev_anack_o = rsp_ok && (ph_q == PH_ADDR) && eng_rsp_nack_i;
  assign ev_fail_o  = rsp_ok && (ph_q == PH_WR) && eng_rsp_nack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      op_q   <= OP_READ;
      wait_q <= 1'b0;
      init_q <= 1'b0;
      chip_o <= '0;
      addr_o <= '0;
      alen_o <= '0;
      idx_o  <= '0;
      cnt_q  <= '0;
      byte_q <= '0;
    end else begin
      if (eng_cmd_valid_o && eng_cmd_ready_i) wait_q <= 1'b1;
      case (ph_q)
        PH_IDLE: if (req_valid_i) begin
          op_q   <= (req_op_i == 2'd3) ? OP_WRITE : op_e'(req_op_i);
          chip_o <= req_chip_i;
          addr_o <= req_addr_i;
          alen_o <= req_alen_i;
          cnt_q  <= req_len_i;
          ph_q   <= init_q ? PH_START1 : PH_RESET;
        end
        PH_RDOUT: if (rdata_ready_i) begin
          cnt_q <= cnt_q - LEN_W'(1);
          ph_q  <= last_q ? PH_STOP : PH_RD;
        end
        PH_WGET: if (wdata_valid_i) begin
          byte_q <= wdata_i;
          ph_q   <= PH_WR;
        end
        default: if (rsp_ok) begin
          wait_q <= 1'b0;
          case (ph_q)
            PH_RESET: begin init_q <= 1'b1; ph_q <= PH_START1; end
            PH_START1: ph_q <= (op_q == OP_READ && alen_o == '0) ? PH_CHIPR : PH_CHIPW;
            PH_CHIPW:
              if (eng_rsp_nack_i || op_q == OP_PROBE) ph_q <= PH_STOP;
              else if (alen_o != '0) begin
                idx_o <= alen_o - ALEN_W'(1);
                ph_q  <= PH_ADDR;
              end else ph_q <= (cnt_q != '0) ? PH_WGET : PH_STOP;
            PH_ADDR:
              if (eng_rsp_nack_i) ph_q <= PH_STOP;
              else if (idx_o != '0) idx_o <= idx_o - ALEN_W'(1);
              else if (op_q == OP_READ) ph_q <= PH_MSTOP;
              else ph_q <= (cnt_q != '0) ? PH_WGET : PH_STOP;
            PH_MSTOP:  ph_q <= PH_START2;
            PH_START2: ph_q <= PH_CHIPR;
            PH_CHIPR:  ph_q <= (cnt_q != '0) ? PH_RD : PH_STOP;
            PH_RD: begin byte_q <= eng_rsp_data_i; ph_q <= PH_RDOUT; end
            PH_WR: begin
              cnt_q <= cnt_q - LEN_W'(1);
              ph_q  <= last_q ? PH_STOP : PH_WGET;
            end
            default:   ph_q <= PH_IDLE;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_seq_top.sv
`timescale 1ns/1ps
module i2c_seq_top
  import i2c_seq_pkg::*;
#(
  parameter int         ADDR_BYTES = 4,
  parameter int         LEN_W      = 8,
  parameter logic [6:0] OVF_MASK   = 7'h00,
  localparam int        ALEN_W     = $clog2(ADDR_BYTES + 1),
  localparam int        AW         = ADDR_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [6:0]        req_chip_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [ALEN_W-1:0] req_alen_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              wdata_valid_i,
  output logic              wdata_ready_o,
  input  logic [7:0]        wdata_i,
  output logic              rdata_valid_o,
  input  logic              rdata_ready_i,
  output logic [7:0]        rdata_o,
  output logic              eng_cmd_valid_o,
  input  logic              eng_cmd_ready_i,
  output logic [2:0]        eng_cmd_o,
  output logic [7:0]        eng_cmd_data_o,
  input  logic              eng_rsp_valid_i,
  input  logic              eng_rsp_nack_i,
  input  logic [7:0]        eng_rsp_data_i,
  output logic              st_done_o,
  output logic              st_nodev_o,
  output logic              st_addr_nack_o,
  output logic [7:0]        st_fail_cnt_o
);
  logic [6:0]        chip_q, chip_eff;
  logic [AW-1:0]     addr_q;
  logic [ALEN_W-1:0] alen_q, idx_q;
  logic [7:0]        addr_byte;
  logic              ev_clr, ev_done, ev_nodev, ev_anack, ev_fail;
  status_t           st;

  i2c_seq_ctrl #(.ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W)) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_op_i, .req_chip_i,
    .req_addr_i, .req_alen_i, .req_len_i, .wdata_valid_i, .wdata_ready_o,
    .wdata_i, .rdata_valid_o, .rdata_ready_i, .rdata_o, .eng_cmd_valid_o,
    .eng_cmd_ready_i, .eng_cmd_o, .eng_cmd_data_o, .eng_rsp_valid_i,
    .eng_rsp_nack_i, .eng_rsp_data_i,
    .chip_o(chip_q), .addr_o(addr_q), .alen_o(alen_q), .idx_o(idx_q),
    .chip_eff_i(chip_eff), .addr_byte_i(addr_byte),
    .ev_clr_o(ev_clr), .ev_done_o(ev_done), .ev_nodev_o(ev_nodev),
    .ev_anack_o(ev_anack), .ev_fail_o(ev_fail)
  );

  i2c_seq_addr #(.ADDR_BYTES(ADDR_BYTES), .OVF_MASK(OVF_MASK)) u_addr (
    .chip_i(chip_q), .addr_i(addr_q), .alen_i(alen_q), .idx_i(idx_q),
    .chip_eff_o(chip_eff), .addr_byte_o(addr_byte)
  );

  i2c_seq_status u_status (
    .clk_i, .rst_ni, .clr_i(ev_clr), .done_i(ev_done), .nodev_i(ev_nodev),
    .anack_i(ev_anack), .fail_i(ev_fail), .st_o(st)
  );

  assign st_done_o      = st.done;
  assign st_nodev_o     = st.nodev;
  assign st_addr_nack_o = st.addr_nack;
  assign st_fail_cnt_o  = st.fails;
endmodule

// File: rtl/i2c_seq_chk.sv
`timescale 1ns/1ps
module i2c_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       wdata_ready_o,
  input logic       rdata_valid_o,
  input logic       rdata_ready_i,
  input logic [7:0] rdata_o,
  input logic       eng_cmd_valid_o,
  input logic       eng_cmd_ready_i,
  input logic [2:0] eng_cmd_o,
  input logic [7:0] eng_cmd_data_o,
  input logic       st_done_o,
  input logic       st_nodev_o,
  input logic       st_addr_nack_o,
  input logic [7:0] st_fail_cnt_o
);
  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_cmd_valid_o && !eng_cmd_ready_i |=> eng_cmd_valid_o && $stable(eng_cmd_o) && $stable(eng_cmd_data_o)); // R12
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_valid_o && !rdata_ready_i |=> rdata_valid_o && $stable(rdata_o)); // R6
  AST_ONE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({eng_cmd_valid_o, rdata_valid_o, wdata_ready_o, req_ready_o})); // R9
  AST_DONE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !st_done_o); // R11
  AST_STAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o && !req_valid_i |=> $stable({st_done_o, st_nodev_o, st_addr_nack_o, st_fail_cnt_o})); // R11
  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(st_nodev_o && st_addr_nack_o)); // R8
  AST_END_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_done_o) |-> $past(eng_cmd_o) == 3'd2); // R7
endmodule

bind i2c_seq_top i2c_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .wdata_ready_o(wdata_ready_o), .rdata_valid_o(rdata_valid_o), .rdata_ready_i(rdata_ready_i),
  .rdata_o(rdata_o), .eng_cmd_valid_o(eng_cmd_valid_o), .eng_cmd_ready_i(eng_cmd_ready_i),
  .eng_cmd_o(eng_cmd_o), .eng_cmd_data_o(eng_cmd_data_o), .st_done_o(st_done_o),
  .st_nodev_o(st_nodev_o), .st_addr_nack_o(st_addr_nack_o), .st_fail_cnt_o(st_fail_cnt_o)
);

// File: tb/test_i2c_seq_top.sv
`timescale 1ns/1ps
module test_i2c_seq_top;
  localparam int C_RST = 0, C_STA = 1, C_STO = 2, C_WR = 3, C_RA = 4, C_RN = 5;
  localparam int OP_RD = 0, OP_WRT = 1, OP_PRB = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_op = '0;
  logic [6:0]  req_chip = '0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_alen = '0;
  logic [7:0]  req_len = '0;
  logic        wdata_valid, wdata_ready, rdata_valid, rdata_ready;
  logic [7:0]  wdata, rdata;
  logic        cmd_valid, cmd_ready;
  logic [2:0]  cmd;
  logic [7:0]  cmd_data;
  logic        rsp_valid = 1'b0, rsp_nack = 1'b0;
  logic [7:0]  rsp_data = '0;
  logic        st_done, st_nodev, st_anack;
  logic [7:0]  st_fail;

  int cyc = 0, log_n = 0, rcnt = 0, wcnt = 0, base = 0, rbase = 0;
  int n_tests = 0, n_fail = 0;
  logic [2:0] exp_cmd [32];
  logic [7:0] exp_dat [32];
  logic       exp_nack [32];
  logic [7:0] exp_rd [32];
  logic [2:0] log_cmd [32];
  logic [7:0] log_dat [32];
  logic [7:0] rd_got [8];
  int exp_n, exp_fails, exp_rdn;
  bit exp_nodev, exp_anack;

  assign cmd_ready   = (cyc % 3) != 1;
  assign rdata_ready = cyc[0];
  assign wdata_valid = (cyc % 4) != 2;
  assign wdata       = 8'h50 + 8'(wcnt * 7);

  i2c_seq_top #(.ADDR_BYTES(4), .LEN_W(8), .OVF_MASK(7'h03)) i_i2c_seq_top (
    .clk_i, .rst_ni, .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_chip_i(req_chip), .req_addr_i(req_addr), .req_alen_i(req_alen), .req_len_i(req_len),
    .wdata_valid_i(wdata_valid), .wdata_ready_o(wdata_ready), .wdata_i(wdata),
    .rdata_valid_o(rdata_valid), .rdata_ready_i(rdata_ready), .rdata_o(rdata),
    .eng_cmd_valid_o(cmd_valid), .eng_cmd_ready_i(cmd_ready), .eng_cmd_o(cmd),
    .eng_cmd_data_o(cmd_data), .eng_rsp_valid_i(rsp_valid), .eng_rsp_nack_i(rsp_nack),
    .eng_rsp_data_i(rsp_data), .st_done_o(st_done), .st_nodev_o(st_nodev),
    .st_addr_nack_o(st_anack), .st_fail_cnt_o(st_fail)
  );

  // engine model and byte-port partners
  always @(posedge clk_i) begin
    int k;
    cyc <= cyc + 1;
    rsp_valid <= 1'b0;
    if (cmd_valid && cmd_ready) begin
      k = log_n - base;
      if (k >= 0 && k < 32) begin
        log_cmd[k]  <= cmd;
        log_dat[k]  <= (cmd == 3'(C_WR)) ? cmd_data : 8'h00;
        rsp_nack    <= exp_nack[k];
        rsp_data    <= exp_rd[k];
      end
      rsp_valid <= 1'b1;
      log_n <= log_n + 1;
    end
    if (wdata_valid && wdata_ready) wcnt <= wcnt + 1;
    if (rdata_valid && rdata_ready) begin
      if (rcnt - rbase < 8) rd_got[rcnt - rbase] <= rdata;
      rcnt <= rcnt + 1;
    end
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rdv(input int j);
    return 8'hC3 ^ 8'(j * 29);
  endfunction

  task automatic push(input int c, input logic [7:0] d, input bit nk, input logic [7:0] rd);
    exp_cmd[exp_n] = 3'(c); exp_dat[exp_n] = d; exp_nack[exp_n] = nk; exp_rd[exp_n] = rd;
    exp_n++;
  endtask

  task automatic build(input int op, input logic [6:0] chip, input logic [31:0] addr,
                       input int alen, input int len, input bit first, input bit nodev,
                       input int anack_at, input logic [3:0] dmask);
    logic [6:0] eff;
    int wb;
    exp_n = 0; exp_fails = 0; exp_rdn = 0; exp_nodev = 0; exp_anack = 0; wb = wcnt;
    eff = chip | 7'((64'(addr) >> (alen * 8)) & 64'h3);
    if (first) push(C_RST, 0, 0, 0);
    push(C_STA, 0, 0, 0);
    if (!(op == OP_RD && alen == 0)) begin
      push(C_WR, {eff, 1'b0}, nodev, 0);
      if (nodev) begin exp_nodev = 1; push(C_STO, 0, 0, 0); return; end
      if (op == OP_PRB) begin push(C_STO, 0, 0, 0); return; end
      for (int k = alen - 1; k >= 0; k--) begin
        push(C_WR, addr[k*8 +: 8], anack_at == k, 0);
        if (anack_at == k) begin exp_anack = 1; push(C_STO, 0, 0, 0); return; end
      end
      if (op == OP_RD) begin push(C_STO, 0, 0, 0); push(C_STA, 0, 0, 0); end
    end
    if (op == OP_RD) begin
      push(C_WR, {eff, 1'b1}, 0, 0);
      for (int j = 0; j < len; j++) push((j == len - 1) ? C_RN : C_RA, 0, 0, rdv(j));
      exp_rdn = len;
    end else begin
      for (int j = 0; j < len; j++) begin
        push(C_WR, 8'h50 + 8'((wb + j) * 7), dmask[j], 0);
        if (dmask[j]) exp_fails++;
      end
    end
    push(C_STO, 0, 0, 0);
  endtask

  task automatic run(input int op, input logic [6:0] chip, input logic [31:0] addr,
                     input int alen, input int len, input bit first, input bit nodev,
                     input int anack_at, input logic [3:0] dmask, input string tag);
    int t, bad;
    build(op, chip, addr, alen, len, first, nodev, anack_at, dmask);
    @(negedge clk_i);
    base = log_n; rbase = rcnt;
    req_op = 2'(op); req_chip = chip; req_addr = addr; req_alen = 3'(alen); req_len = 8'(len);
    req_valid = 1'b1;
    @(negedge clk_i);
    req_valid = 1'b0;
    check(!st_done, {tag, " R11 done cleared"}, int'(st_done), 0);
    t = 0;
    while (!(req_ready && st_done) && t < 3000) begin @(negedge clk_i); t++; end
    check(t < 3000, {tag, " watchdog"}, t, 3000);
    check(log_n - base == exp_n, {tag, " R12 command count"}, log_n - base, exp_n);
    bad = -1;
    for (int i = 0; i < exp_n && i < 32; i++)
      if (bad < 0 && (log_cmd[i] !== exp_cmd[i] || log_dat[i] !== exp_dat[i])) bad = i;
    if (bad >= 0) check(0, {tag, " R12 command sequence"}, {log_cmd[bad], log_dat[bad]},
                        {exp_cmd[bad], exp_dat[bad]});
    else check(1, tag, 0, 0);
    check(st_nodev == exp_nodev, {tag, " R7 R10 nodev flag"}, int'(st_nodev), int'(exp_nodev));
    check(st_anack == exp_anack, {tag, " R8 addr flag"}, int'(st_anack), int'(exp_anack));
    check(st_fail == 8'(exp_fails), {tag, " R9 fail count"}, st_fail, exp_fails);
    check(rcnt - rbase == exp_rdn, {tag, " R6 read bytes"}, rcnt - rbase, exp_rdn);
    for (int j = 0; j < exp_rdn && j < 8; j++)
      check(rd_got[j] == rdv(j), {tag, " R6 read data"}, rd_got[j], rdv(j));
    repeat (3) @(negedge clk_i);
    check(st_done && st_fail == 8'(exp_fails), {tag, " R11 status held"}, int'(st_done), 1);
  endtask

  initial begin
    logic [31:0] a;
    a = 32'hDEB1_6A37;
    repeat (3) @(negedge clk_i);
    check(req_ready && !st_done && !st_nodev && !st_anack && st_fail == 0 && !cmd_valid,
          "R11 reset state", {req_ready, st_done, st_nodev, st_anack, cmd_valid}, 5'b10000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run(OP_PRB, 7'h50, a, 1, 0, 1, 0, -1, 4'h0, "R1 R10 probe present with bus reset");
    run(OP_PRB, 7'h21, a, 0, 0, 0, 1, -1, 4'h0, "R1 R10 probe absent");
    for (int al = 0; al <= 4; al++)
      for (int ln = 0; ln <= 3; ln++) begin
        run(OP_WRT, 7'h50, a, al, ln, 0, 0, -1, 4'h0, "R2 R3 R9 write");
        run(OP_WRT, 7'h44, a, al, ln, 0, 0, -1, 4'b0101 ^ 4'(al), "R9 write with data nacks");
      end
    for (int al = 0; al <= 4; al++)
      for (int ln = 1; ln <= 3; ln++)
        run(OP_RD, 7'h50, a, al, ln, 0, 0, -1, 4'h0, "R2 R3 R4 R5 R6 read");
    for (int al = 1; al <= 4; al++) begin
      run(OP_WRT, 7'h50, a, al, 2, 0, 0, 0, 4'h0, "R8 write addr nack last byte");
      run(OP_RD, 7'h50, a, al, 2, 0, 0, al - 1, 4'h0, "R8 read addr nack first byte");
    end
    run(OP_WRT, 7'h18, a, 2, 2, 0, 1, -1, 4'h0, "R7 write no device");
    run(OP_RD, 7'h18, a, 3, 2, 0, 1, -1, 4'h0, "R7 read no device");
    run(OP_RD, 7'h18, a, 0, 1, 0, 0, -1, 4'h0, "R5 read no address after abort");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule